// File: doc/BRIEF.md
# Bidirectional General-Purpose Port with Live Pin Readback

This block is a 16-bit general-purpose I/O port reached over a small memory-mapped register bus. Software picks the direction of each pin, keeps an output latch, and reads either that latch or the live pin level. The register that holds the output value also serves as a read register. For each bit, the direction bit decides whether a read returns the stored latch (output) or the sampled pin (input). A separate read-only register returns the sampled pins for all 16 bits, whatever their direction.

An external pin multiplexer marks each pin as either general I/O or owned by a peripheral. For an owned pin, the peripheral supplies the drive value and the drive enable, and the port's own direction and latch bits no longer reach that pin. They still read back and can still be written. Every pin input passes through a two-stage synchronizer before any readback path uses it.

Register offsets are 0x0 for direction, 0x2 for data latch and 0x4 for the pin mirror. Writes take effect on the clock edge while the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset the direction register and the data latch are all zero, so no general-I/O pin is driven (`pin_oe` bit is 0 wherever `periph_sel` bit is 0).
- R2: A write at offset 0x0 loads the direction register (bit value 1 = output, 0 = input), and a read at offset 0x0 returns it.
- R3: A read at offset 0x2 returns the synchronized pin level in every bit whose direction bit is 0, whether or not that pin is owned by a peripheral.
- R4: A read at offset 0x2 returns the latch value in every bit whose direction bit is 1, whether or not that pin is owned by a peripheral.
- R5: A write at offset 0x2 updates all 16 latch bits regardless of direction bits and of `periph_sel`.
- R6: For a bit with `periph_sel` 0, `pin_oe` equals the direction bit and `pin_out` equals the latch bit, so written data drives the pin only when the direction is 1.
- R7: For a bit with `periph_sel` 1, `pin_out` equals `periph_out` and `pin_oe` equals `periph_oe` for that bit.
- R8: A read at offset 0x4 returns the synchronized level of all 16 pins (1 = high, 0 = low) regardless of direction or ownership. A write at 0x4 changes neither the direction register nor the latch.
- R9: A change on `pin_in` shows up in readback after exactly two rising clock edges and not after one.
- R10: A read at any offset other than 0x0, 0x2 or 0x4 returns zero. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 16 | Levels sampled on the pads |
| periph_sel | input | 16 | Per-pin ownership: 1 = peripheral, 0 = general I/O |
| periph_out | input | 16 | Peripheral drive values |
| periph_oe | input | 16 | Peripheral drive enables |
| pin_out | output | 16 | Pad drive values |
| pin_oe | output | 16 | Pad drive enables |

## Verification
The bench mixes direction patterns with peripheral ownership so that each data-register bit must pick the latch or the pin by its own direction bit. A design that selected by ownership, or by one global mode, would return the wrong half of the word. It writes the latch while every pin is peripheral-owned and as inputs, then hands the pins back to general output. A design that gated latch writes by mode would then drive stale data. It also times a pin change edge by edge to catch a synchronizer that is missing a stage or has one too many. Finally, it writes to the read-only and unmapped offsets to catch address decoding that is too loose and corrupts the direction register or the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFF_DIR  = 0;
  localparam int unsigned OFF_DATA = 2;
  localparam int unsigned OFF_PORT = 4;

  typedef enum logic [1:0] {
    RS_DIR,
    RS_DATA,
    RS_PORT,
    RS_NONE
  } rsel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // No reset: the mirror has no fixed reset value, it follows the pads.
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    st[0] <= d;
    for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dir,
  input  logic         wr_dat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      // Latch is written whatever the direction or ownership.
      if (wr_dat) lat_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int W = 16
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] p_out,
  input  logic [W-1:0] p_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pad_out[i] = sel[i] ? p_out[i] : lat_q[i];
    assign pad_oe[i]  = sel[i] ? p_oe[i]  : dir_q[i];
  end
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux #(
  parameter int W = 16
) (
  input  gpio_pkg::rsel_e rsel,
  input  logic [W-1:0]    dir_q,
  input  logic [W-1:0]    lat_q,
  input  logic [W-1:0]    pins_s,
  output logic [W-1:0]    rdata
);
  logic [W-1:0] data_view;

  for (genvar i = 0; i < W; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? lat_q[i] : pins_s[i];
  end

  always_comb begin
    case (rsel)
      gpio_pkg::RS_DIR:  rdata = dir_q;
      gpio_pkg::RS_DATA: rdata = data_view;
      gpio_pkg::RS_PORT: rdata = pins_s;
      default:           rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  periph_sel,
  input  logic [WIDTH-1:0]  periph_out,
  input  logic [WIDTH-1:0]  periph_oe,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  import gpio_pkg::*;

  rsel_e            rsel;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] pins_s;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_DIR))  rsel = RS_DIR;
    else if (bus_addr == ADDR_W'(OFF_DATA)) rsel = RS_DATA;
    else if (bus_addr == ADDR_W'(OFF_PORT)) rsel = RS_PORT;
    else                                    rsel = RS_NONE;
  end

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_in),
    .q   (pins_s)
  );

  gpio_regs #(.W(WIDTH)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_dir (bus_wr && rsel == RS_DIR),
    .wr_dat (bus_wr && rsel == RS_DATA),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .lat_q  (lat_q)
  );

  gpio_pinmux #(.W(WIDTH)) u_mux (
    .sel     (periph_sel),
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .p_out   (periph_out),
    .p_oe    (periph_oe),
    .pad_out (pin_out),
    .pad_oe  (pin_oe)
  );

  gpio_readmux #(.W(WIDTH)) u_rd (
    .rsel   (rsel),
    .dir_q  (dir_q),
    .lat_q  (lat_q),
    .pins_s (pins_s),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W      = 16,
  parameter int ADDR_W = 3,
  parameter int SYNC   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pin_in,
  input logic [W-1:0]      periph_sel,
  input logic [W-1:0]      periph_out,
  input logic [W-1:0]      periph_oe,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      lat_q
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(gpio_pkg::OFF_DIR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(gpio_pkg::OFF_DATA);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(gpio_pkg::OFF_PORT);

  AST_RESET_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((pin_oe & ~periph_sel) == '0)); // R1

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DIR) |=> ((pin_oe & ~periph_sel) == ($past(bus_wdata) & ~periph_sel))); // R6

  AST_LATCH_TO_PAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA) |=> ((pin_out & ~periph_sel) == ($past(bus_wdata) & ~periph_sel))); // R5

  AST_PERIPH_OWNS: assert property (@(posedge clk) disable iff (rst)
    (((pin_oe ^ periph_oe) | (pin_out ^ periph_out)) & periph_sel) == '0); // R7

  AST_RO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != A_DIR && bus_addr != A_DATA) |=> ($stable(dir_q) && $stable(lat_q))); // R8

  if (SYNC == 2) begin : g_lag
    AST_MIRROR_LAG: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == A_PORT) |-> (bus_rdata == $past(pin_in, 2))); // R9
  end
endmodule

bind gpio_port gpio_port_chk #(.W(WIDTH), .ADDR_W(ADDR_W), .SYNC(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_in     (pin_in),
  .periph_sel (periph_sel),
  .periph_out (periph_out),
  .periph_oe  (periph_oe),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .dir_q      (dir_q),
  .lat_q      (lat_q)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = 16'hA5C3;
  logic [W-1:0] periph_sel = '0;
  logic [W-1:0] periph_out = '0;
  logic [W-1:0] periph_oe = '0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_sel(periph_sel), .periph_out(periph_out), .periph_oe(periph_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // dir, data, sel, pins, periph_out, periph_oe
  typedef struct packed {
    logic [W-1:0] dir;
    logic [W-1:0] dat;
    logic [W-1:0] sel;
    logic [W-1:0] pins;
    logic [W-1:0] pout;
    logic [W-1:0] poe;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'hFFFF, 16'h1234, 16'h0000, 16'h0F0F, 16'h0000, 16'h0000},
    '{16'h0000, 16'hBEEF, 16'h0000, 16'h5A5A, 16'h0000, 16'h0000},
    '{16'hFF00, 16'h00FF, 16'h0F0F, 16'h3C3C, 16'hAAAA, 16'h5555},
    '{16'h00FF, 16'hCAFE, 16'hFFFF, 16'h9669, 16'h1111, 16'h8888}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 pin_oe after reset", pin_oe, 16'h0000);
    rd(3'd0, r); check("R1 dir after reset", r, 16'h0000);
    rd(3'd2, r); check("R3 data reads pins after reset", r, 16'hA5C3);
    rd(3'd4, r); check("R8 mirror after reset", r, 16'hA5C3);

    foreach (VECS[k]) begin
      @(negedge clk);
      periph_sel = VECS[k].sel; periph_out = VECS[k].pout;
      periph_oe = VECS[k].poe; pin_in = VECS[k].pins;
      wr(3'd0, VECS[k].dir);
      wr(3'd2, VECS[k].dat);
      @(negedge clk);
      rd(3'd0, r); check("R2 dir readback", r, VECS[k].dir);
      rd(3'd2, r);
      check("R3 R4 data view", r, (VECS[k].dir & VECS[k].dat) | (~VECS[k].dir & VECS[k].pins));
      rd(3'd4, r); check("R8 mirror", r, VECS[k].pins);
      check("R6 R7 pin_oe", pin_oe, (VECS[k].sel & VECS[k].poe) | (~VECS[k].sel & VECS[k].dir));
      check("R6 R7 pin_out", pin_out, (VECS[k].sel & VECS[k].pout) | (~VECS[k].sel & VECS[k].dat));
    end

    // R5: latch written while inputs and peripheral-owned, then released.
    @(negedge clk);
    periph_sel = 16'hFFFF;
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h7E81);
    @(negedge clk);
    periph_sel = 16'h0000;
    wr(3'd0, 16'hFFFF);
    rd(3'd2, r); check("R5 latch kept through input/peripheral mode", r, 16'h7E81);
    check("R5 R6 pad drives latch", pin_out, 16'h7E81);
    check("R6 pad enabled", pin_oe, 16'hFFFF);

    // R6: input direction writes do not drive.
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'hFFFF);
    #1;
    check("R6 no drive when input", pin_oe, 16'h0000);

    // R8: write to the mirror is ignored.
    wr(3'd0, 16'h00F0);
    wr(3'd2, 16'h1357);
    wr(3'd4, 16'hDEAD);
    rd(3'd0, r); check("R8 dir unchanged by mirror write", r, 16'h00F0);
    rd(3'd4, r); check("R8 mirror still pins", r, pin_in);
    check("R8 latch unchanged by mirror write", pin_out, 16'h1357);

    // R10: unmapped offsets.
    wr(3'd6, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    rd(3'd6, r); check("R10 unmapped reads zero", r, 16'h0000);
    rd(3'd3, r); check("R10 odd offset reads zero", r, 16'h0000);
    rd(3'd0, r); check("R10 dir unchanged", r, 16'h00F0);
    check("R10 latch unchanged", pin_out, 16'h1357);

    // R9: two-edge latency.
    wr(3'd0, 16'h0000);
    @(negedge clk);
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    pin_in = 16'hFFFF;
    @(negedge clk);
    rd(3'd4, r); check("R9 not visible after one edge", r, 16'h0000);
    @(negedge clk);
    rd(3'd4, r); check("R9 visible after two edges", r, 16'hFFFF);
    rd(3'd2, r); check("R9 R3 data view after two edges", r, 16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule